// File: doc/BRIEF.md
# SDRAM Command Timing Enforcer

This block sits between the command scheduler of an SDRAM controller and the memory command bus. The scheduler offers one command at a time, together with a bank index. The block lets the command through only when every inter-command delay that applies to it has run out. Seven delays come from one 32-bit programmable timing register. Each delay is a 4-bit count of memory clock cycles. A field value N forces a spacing of N+1 cycles between the two commands it relates.

Three delays are tracked for each bank: row-open to column access, write to precharge, and precharge to the next command. The other four are global and block every bank: mode-register load, refresh cycle, minimum self-refresh residency and self-refresh exit. Each delay is a down-counter. The counter reloads from the register in the same cycle that the command which starts the delay is issued. A new register value therefore affects only commands issued after the write. It does not shorten or lengthen a delay that is already counting.

The handshake has no registers in it. `req_ready` is a combinational result of the counters and the offered command. The issued command appears on `cmd_*` in the same cycle it is accepted. A stalled request keeps `req_ready` low and must stay unchanged on the inputs until it is accepted.

Top module: `sdram_cmd_timer`

## Requirements
- R1: After reset the timing register reads back 0x0FFF_FFFF, so every delay field starts at 15.
- R2: A register write updates the register at the next clock edge. Bits 31:28 always read back 0.
- R3: Command codes on `req_op` are: 0 mode load, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 self-refresh entry, 7 self-refresh exit. A field value N means the second command may issue no earlier than N+1 cycles after the first. When no delay applies, the command is accepted and shown on `cmd_*` in the same cycle it is offered.
- R4: After a mode load, activate and refresh are held off for the field at bits 3:0.
- R5: After a self-refresh exit, activate is held off for the field at bits 7:4.
- R6: After a self-refresh entry, self-refresh exit is held off for the field at bits 11:8.
- R7: After a refresh, activate and refresh are held off for the field at bits 15:12.
- R8: After a write to a bank, a precharge to that bank is held off for the field at bits 19:16.
- R9: After a precharge to a bank, any activate, read, write or precharge to that bank is held off for the field at bits 23:20. Mode load, refresh and both self-refresh commands wait until the precharge delay of every bank has run out.
- R10: After an activate to a bank, a read or write to that bank is held off for the field at bits 27:24.
- R11: The per-bank delays of one bank never stall a command addressed to another bank.
- R12: While a request is stalled, `req_ready` and `cmd_valid` stay low. A delay uses the field value held in the register in the cycle its starting command issued, even if the register is rewritten before the delay ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_wdata | input | 32 | Timing register write value |
| cfg_rdata | output | 32 | Timing register read-back |
| req_valid | input | 1 | A command is offered |
| req_op | input | 3 | Offered command code (see R3) |
| req_bank | input | BANK_W (2) | Bank addressed by the offered command |
| req_ready | output | 1 | Offered command may issue this cycle |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_op | output | 3 | Issued command code |
| cmd_bank | output | BANK_W (2) | Issued command bank |

## Verification
`req_ready` and the `cmd_*` outputs belong to the same cycle as the request, so the bench drives inputs on the falling edge and compares them one time unit later, in that cycle. The delay counters and the timing register take a new value at the next rising edge, so the bench model applies issues and writes only after that edge. For a field value N, the reference expects the dependent command to be refused for exactly N cycles and accepted in the (N+1)-th cycle after the first command. Directed sequences measure these issue-to-issue gaps for each delay. The random phase then compares readiness every cycle against earliest-issue cycle numbers computed in the bench.

// File: rtl/sdt_pkg.sv
// Shared definitions for the SDRAM command timing enforcer.
// Assumes the command codes below are fixed by the scheduler interface.
package sdt_pkg;

    typedef enum logic [2:0] {
        OP_MODE = 3'd0,
        OP_ACT  = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_PRE  = 3'd4,
        OP_REF  = 3'd5,
        OP_SRE  = 3'd6,
        OP_SRX  = 3'd7
    } sdt_op_e;

    // Field slot numbers inside the timing register (slot k sits at bits 4k+3:4k).
    localparam int F_MRD  = 0;
    localparam int F_XSR  = 1;
    localparam int F_SRP  = 2;
    localparam int F_RC   = 3;
    localparam int F_WR   = 4;
    localparam int F_RP   = 5;
    localparam int F_RCD  = 6;
    localparam int NUM_FLD = 7;

endpackage

// File: rtl/sdt_cfg_reg.sv
// Timing register: holds NUM_FLD packed delay fields and reads back with
// the unused top bits forced to zero. Assumes single-cycle writes.
module sdt_cfg_reg #(
    parameter int REG_W   = 32,
    parameter int FIELD_W = 4,
    parameter int NUM_FLD = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata
);
    localparam int USED_W = FIELD_W * NUM_FLD;
    localparam logic [REG_W-1:0] USED_MASK = {{(REG_W-USED_W){1'b0}}, {USED_W{1'b1}}};

    logic [USED_W-1:0] fields_q;

    // Store the written value; reset loads every field with its maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)  fields_q <= {USED_W{1'b1}};
        else if (we) fields_q <= wdata[USED_W-1:0];
    end

    assign rdata = {{(REG_W-USED_W){1'b0}}, fields_q};

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata == ($past(wdata) & USED_MASK)));
endmodule

// File: rtl/sdt_down_cnt.sv
// Loadable down-counter that stops at zero; zero means the delay is over.
// Assumes a load value of N should free the gated command N+1 cycles after
// the load cycle.
module sdt_down_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    // Reload on a starting command, else count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    a_r3_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sdt_bank_timers.sv
// Per-bank delay counters: row-open to column, write recovery and
// precharge. One load strobe per bank per delay; one done flag per bank.
module sdt_bank_timers #(
    parameter int NUM_BANKS = 4,
    parameter int FIELD_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] ld_rcd,
    input  logic [NUM_BANKS-1:0] ld_wr,
    input  logic [NUM_BANKS-1:0] ld_rp,
    input  logic [FIELD_W-1:0]   val_rcd,
    input  logic [FIELD_W-1:0]   val_wr,
    input  logic [FIELD_W-1:0]   val_rp,
    output logic [NUM_BANKS-1:0] ok_rcd,
    output logic [NUM_BANKS-1:0] ok_wr,
    output logic [NUM_BANKS-1:0] ok_rp
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdt_down_cnt #(.W(FIELD_W)) u_rcd (
            .clk(clk), .rst_n(rst_n), .load(ld_rcd[b]), .load_val(val_rcd), .done(ok_rcd[b]));
        sdt_down_cnt #(.W(FIELD_W)) u_wr (
            .clk(clk), .rst_n(rst_n), .load(ld_wr[b]), .load_val(val_wr), .done(ok_wr[b]));
        sdt_down_cnt #(.W(FIELD_W)) u_rp (
            .clk(clk), .rst_n(rst_n), .load(ld_rp[b]), .load_val(val_rp), .done(ok_rp[b]));
    end
endmodule

// File: rtl/sdram_cmd_timer.sv
// SDRAM command timing enforcer. Accepts one command per cycle from the
// scheduler and passes it on only when all programmed inter-command delays
// have run out. Assumes a stalled request is held unchanged until accepted.
module sdram_cmd_timer
    import sdt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int FIELD_W   = 4,
    parameter int REG_W     = 32,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [BANK_W-1:0] req_bank,
    output logic              req_ready,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank
);
    localparam logic [NUM_BANKS-1:0] ONE_BANK = {{(NUM_BANKS-1){1'b0}}, 1'b1};

    logic [FIELD_W-1:0]   fld [NUM_FLD];
    logic                 ok_mrd, ok_xsr, ok_srp, ok_rc;
    logic [NUM_BANKS-1:0] ok_rcd, ok_wr, ok_rp;
    logic [NUM_BANKS-1:0] bank_sel, ld_rcd, ld_wr, ld_rp;
    logic                 banked, bank_ok, glob_ok, issue;

    sdt_cfg_reg #(.REG_W(REG_W), .FIELD_W(FIELD_W), .NUM_FLD(NUM_FLD)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .rdata(cfg_rdata));

    for (genvar k = 0; k < NUM_FLD; k++) begin : g_fld
        assign fld[k] = cfg_rdata[k*FIELD_W +: FIELD_W];
    end

    // Global delays, each started by one command type.
    sdt_down_cnt #(.W(FIELD_W)) u_mrd (.clk(clk), .rst_n(rst_n),
        .load(issue && req_op == OP_MODE), .load_val(fld[F_MRD]), .done(ok_mrd));
    sdt_down_cnt #(.W(FIELD_W)) u_xsr (.clk(clk), .rst_n(rst_n),
        .load(issue && req_op == OP_SRX), .load_val(fld[F_XSR]), .done(ok_xsr));
    sdt_down_cnt #(.W(FIELD_W)) u_srp (.clk(clk), .rst_n(rst_n),
        .load(issue && req_op == OP_SRE), .load_val(fld[F_SRP]), .done(ok_srp));
    sdt_down_cnt #(.W(FIELD_W)) u_rc  (.clk(clk), .rst_n(rst_n),
        .load(issue && req_op == OP_REF), .load_val(fld[F_RC]), .done(ok_rc));

    // Per-bank load strobes for the addressed bank.
    always_comb begin
        bank_sel = ONE_BANK << req_bank;
        ld_rcd   = (issue && req_op == OP_ACT) ? bank_sel : '0;
        ld_wr    = (issue && req_op == OP_WR)  ? bank_sel : '0;
        ld_rp    = (issue && req_op == OP_PRE) ? bank_sel : '0;
    end

    sdt_bank_timers #(.NUM_BANKS(NUM_BANKS), .FIELD_W(FIELD_W)) u_banks (
        .clk(clk), .rst_n(rst_n),
        .ld_rcd(ld_rcd), .ld_wr(ld_wr), .ld_rp(ld_rp),
        .val_rcd(fld[F_RCD]), .val_wr(fld[F_WR]), .val_rp(fld[F_RP]),
        .ok_rcd(ok_rcd), .ok_wr(ok_wr), .ok_rp(ok_rp));

    // Decide whether the offered command satisfies every applicable delay.
    always_comb begin
        banked  = (req_op == OP_ACT) || (req_op == OP_RD) ||
                  (req_op == OP_WR)  || (req_op == OP_PRE);
        bank_ok = ok_rp[req_bank];
        if (req_op == OP_RD || req_op == OP_WR) bank_ok = bank_ok && ok_rcd[req_bank];
        if (req_op == OP_PRE)                   bank_ok = bank_ok && ok_wr[req_bank];
        glob_ok = 1'b1;
        if (!banked) glob_ok = &ok_rp;
        if (req_op == OP_ACT || req_op == OP_REF) glob_ok = glob_ok && ok_mrd && ok_rc;
        if (req_op == OP_ACT) glob_ok = glob_ok && ok_xsr;
        if (req_op == OP_SRX) glob_ok = glob_ok && ok_srp;
        req_ready = rst_n && glob_ok && (!banked || bank_ok);
    end

    assign issue     = req_valid && req_ready;
    assign cmd_valid = issue;
    assign cmd_op    = req_op;
    assign cmd_bank  = req_bank;

    // Cross-cycle spacing checks on the issued command stream.
    a_r10_act_to_col: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ACT && fld[F_RCD] != '0) |=>
        !(cmd_valid && (cmd_op == OP_RD || cmd_op == OP_WR) && cmd_bank == $past(cmd_bank)));
    a_r8_wr_to_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WR && fld[F_WR] != '0) |=>
        !(cmd_valid && cmd_op == OP_PRE && cmd_bank == $past(cmd_bank)));
    a_r9_pre_to_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PRE && fld[F_RP] != '0) |=>
        !(cmd_valid && cmd_op inside {OP_ACT, OP_RD, OP_WR, OP_PRE} && cmd_bank == $past(cmd_bank)));
    a_r7_ref_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_REF && fld[F_RC] != '0) |=>
        !(cmd_valid && (cmd_op == OP_ACT || cmd_op == OP_REF)));
    a_r4_mode_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_MODE && fld[F_MRD] != '0) |=>
        !(cmd_valid && (cmd_op == OP_ACT || cmd_op == OP_REF)));
    a_r6_selfref_min: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_SRE && fld[F_SRP] != '0) |=> !(cmd_valid && cmd_op == OP_SRX));
    a_r5_selfref_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_SRX && fld[F_XSR] != '0) |=> !(cmd_valid && cmd_op == OP_ACT));
endmodule

// File: tb/tb_sdram_cmd_timer.sv
`timescale 1ns/1ps
module tb_sdram_cmd_timer;
    localparam int NB = 4;
    localparam logic [31:0] MASK = 32'h0FFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [1:0]  req_bank = '0;
    logic        req_ready, cmd_valid;
    logic [2:0]  cmd_op;
    logic [1:0]  cmd_bank;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [31:0] mreg;
    int e_mrd, e_xsr, e_sr, e_rc;
    int e_rcd [NB];
    int e_wr  [NB];
    int e_rp  [NB];

    always #2 clk = ~clk;

    sdram_cmd_timer dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_op(req_op), .req_bank(req_bank), .req_ready(req_ready),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank));

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic int fld(int k);
        return int'(mreg[k*4 +: 4]);
    endfunction

    // First unmet requirement for the offered command, or "" when legal.
    function automatic string why(logic [2:0] op, int b);
        bit banked = (op >= 3'd1 && op <= 3'd4);
        if (banked && cyc < e_rp[b]) return "R9";
        if (!banked) for (int i = 0; i < NB; i++) if (cyc < e_rp[i]) return "R9";
        if ((op == 3'd2 || op == 3'd3) && cyc < e_rcd[b]) return "R10";
        if (op == 3'd4 && cyc < e_wr[b]) return "R8";
        if ((op == 3'd1 || op == 3'd5) && cyc < e_mrd) return "R4";
        if (op == 3'd1 && cyc < e_xsr) return "R5";
        if (op == 3'd6 + 3'd1 && cyc < e_sr) return "R6";
        if ((op == 3'd1 || op == 3'd5) && cyc < e_rc) return "R7";
        return "";
    endfunction

    task automatic model_issue(logic [2:0] op, int b);
        case (op)
            3'd0: e_mrd  = cyc + fld(0) + 1;
            3'd7: e_xsr  = cyc + fld(1) + 1;
            3'd6: e_sr   = cyc + fld(2) + 1;
            3'd5: e_rc   = cyc + fld(3) + 1;
            3'd3: e_wr[b]  = cyc + fld(4) + 1;
            3'd4: e_rp[b]  = cyc + fld(5) + 1;
            3'd1: e_rcd[b] = cyc + fld(6) + 1;
            default: ;
        endcase
    endtask

    // One cycle: drive on the falling edge, check mid-cycle, update model after the rising edge.
    task automatic step(bit v, logic [2:0] op, int b, bit we, logic [31:0] wd, string dflt, output bit issued);
        string w;
        bit exp;
        @(negedge clk);
        req_valid = v; req_op = op; req_bank = 2'(b); cfg_we = we; cfg_wdata = wd;
        #1;
        w = why(op, b);
        exp = (w == "");
        chk(req_ready === exp, exp ? dflt : w, "req_ready", 32'(req_ready), 32'(exp));
        chk((cmd_valid === (v && exp)) && (!cmd_valid || (cmd_op === op && cmd_bank === 2'(b))),
            exp ? dflt : "R12", "cmd_valid/op/bank", {cmd_valid, cmd_op, cmd_bank}, {v && exp, op, 2'(b)});
        chk(cfg_rdata === mreg, "R2", "cfg_rdata", cfg_rdata, mreg);
        issued = v && exp;
        @(posedge clk);
        if (issued) model_issue(op, b);
        if (we) mreg = wd & MASK;
        cyc++;
    endtask

    task automatic issue_wait(logic [2:0] op, int b, string dflt, output int t);
        bit iss = 1'b0;
        t = -1;
        for (int n = 0; n < 40 && !iss; n++) begin
            t = cyc;
            step(1'b1, op, b, 1'b0, '0, dflt, iss);
        end
        if (!iss) chk(1'b0, dflt, "command never issued", 32'(op), 32'(op));
    endtask

    task automatic idle(bit we, logic [31:0] wd, string dflt);
        bit iss;
        step(1'b0, 3'd0, 0, we, wd, dflt, iss);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int t0, t1, t2, t3, t4;
        bit iss;
        mreg = MASK;
        e_mrd = 0; e_xsr = 0; e_sr = 0; e_rc = 0;
        for (int i = 0; i < NB; i++) begin e_rcd[i] = 0; e_wr[i] = 0; e_rp[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk);
        // R1: reset value read back, nothing pending.
        idle(1'b0, '0, "R1");
        chk(cfg_rdata === 32'h0FFF_FFFF, "R1", "reset value", cfg_rdata, 32'h0FFF_FFFF);
        // R2: top bits always read zero.
        idle(1'b1, 32'hFFFF_FFFF, "R2");
        idle(1'b1, 32'h0321_4521, "R2");
        idle(1'b0, '0, "R2");
        // R10 / R3: activate then read same bank, rcd=3 -> gap 4.
        issue_wait(3'd1, 0, "R3", t0);
        issue_wait(3'd2, 0, "R10", t1);
        chk(t1 - t0 == 4, "R10", "act->rd gap", 32'(t1 - t0), 32'd4);
        // R11: other bank not stalled by bank 0.
        issue_wait(3'd1, 1, "R11", t2);
        chk(t2 - t1 == 1, "R11", "other bank immediate", 32'(t2 - t1), 32'd1);
        // R8: write then precharge, wr=1 -> gap 2.
        issue_wait(3'd3, 0, "R8", t2);
        issue_wait(3'd4, 0, "R8", t3);
        chk(t3 - t2 == 2, "R8", "wr->pre gap", 32'(t3 - t2), 32'd2);
        // R9: precharge then activate same bank, rp=2 -> gap 3.
        issue_wait(3'd1, 0, "R9", t4);
        chk(t4 - t3 == 3, "R9", "pre->act gap", 32'(t4 - t3), 32'd3);
        // R4 and R7: mode load then refresh (gap 2), refresh then refresh (gap 5).
        issue_wait(3'd0, 0, "R4", t0);
        issue_wait(3'd5, 0, "R4", t1);
        chk(t1 - t0 == 2, "R4", "mode->ref gap", 32'(t1 - t0), 32'd2);
        issue_wait(3'd5, 0, "R7", t2);
        chk(t2 - t1 == 5, "R7", "ref->ref gap", 32'(t2 - t1), 32'd5);
        // R6 and R5: self-refresh residency (gap 6) and exit to activate (gap 3).
        issue_wait(3'd6, 0, "R6", t0);
        issue_wait(3'd7, 0, "R6", t1);
        chk(t1 - t0 == 6, "R6", "sre->srx gap", 32'(t1 - t0), 32'd6);
        issue_wait(3'd1, 3, "R5", t2);
        chk(t2 - t1 == 3, "R5", "srx->act gap", 32'(t2 - t1), 32'd3);
        // R12: delay keeps the value latched at issue despite a later rewrite.
        idle(1'b1, 32'h0F21_4521, "R12");
        issue_wait(3'd1, 2, "R12", t0);
        idle(1'b1, 32'h0021_4521, "R12");
        issue_wait(3'd2, 2, "R12", t1);
        chk(t1 - t0 == 16, "R12", "latched rcd gap", 32'(t1 - t0), 32'd16);
        // Random phase with held requests and occasional rewrites.
        begin
            int seed_dummy;
            seed_dummy = $urandom(32'd1234);
        end
        for (int n = 0; n < 1500; n++) begin
            logic [2:0] op;
            int b;
            op = 3'($urandom_range(0, 7));
            b  = int'($urandom_range(0, NB - 1));
            if ((n % 60) == 0) idle(1'b1, $urandom() & 32'hF7777777 | 32'hF0000000, "R2");
            if ($urandom_range(0, 3) == 0) idle(1'b0, '0, "R3");
            else issue_wait(op, b, "R3", t0);
        end
        @(negedge clk);
        req_valid = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule